// File: doc/BRIEF.md
# Hold-Flag Scan Block Decompressor

This block turns a reseeded linear-feedback shift register bit stream into one scan-chain pattern of `M` bits. The chain is split into `B` blocks of equal length. A per-block hold flag chooses the source for that block. A flag of 1 sends the register's output bits straight to the chain. A flag of 0 latches one bit, called the sign bit, and repeats it across the whole block. Repeating one value removes transitions in the chain and so lowers shift power.

Each pattern begins with one update-flag bit. When the update flag is 1, the following `B` bits replace the hold flags. When it is 0, the flags from the previous pattern are reused. A seed word is loaded in parallel while the block is idle, and a start pulse launches one pattern. After the last data bit the block gives a single-cycle capture pulse and then waits for the next seed or start.

Top module: `hfd_top`

## Requirements
- R1: The LFSR state `q[L-1:0]` shifts toward bit 0 each time it advances. Its output bit is `q[0]`, and bit `L-1` takes the XOR of the state bits selected by the tap mask `TAPS`. Asserting `seed_load_i` while idle copies `seed_i` into `q` (`seed_i[0]` is emitted first).
- R2: A `start_i` pulse seen while idle begins a pattern. The first emitted bit is taken as the update flag, and `scan_en_o` stays low in that cycle.
- R3: When the update flag is 1, the next `B` emitted bits become the hold flags. The first of them controls block 0, the next controls block 1, and so on. `scan_en_o` stays low during these `B` cycles.
- R4: When the update flag is 0, the hold-flag load is skipped and the flags of the previous pattern apply again unchanged.
- R5: In a block whose hold flag is 1, `scan_in_o` equals the emitted bit of that cycle.
- R6: In a block whose hold flag is 0, the bit emitted in the block's first data cycle is driven on `scan_in_o` for all `M/B` cycles of the block. The LFSR still advances on every data cycle, so every pattern consumes exactly `M` data bits.
- R7: `scan_en_o` is high for exactly `M` consecutive cycles per pattern. `capture_o` pulses for one cycle directly after the last data cycle, and the block is then idle.
- R8: Synchronous active-high reset leaves the block idle with `scan_en_o` and `capture_o` low, the update flag cleared and every hold flag set to 1.
- R9: `seed_load_i` and `start_i` have no effect while a pattern is in progress.
- R10: With `L=3`, `TAPS=3'b011` (the polynomial 1 + x^2 + x^3) and seed `3'b011`, the first nine emitted bits are 1,1,0,0,1,0,1,1,1. With `M=7` and `B=1` after reset, the scan bits are therefore emitted bits 3 to 9: 0,0,1,0,1,1,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_i | input | L | Seed word loaded into the LFSR |
| seed_load_i | input | 1 | Loads `seed_i` while idle |
| start_i | input | 1 | Starts one pattern while idle |
| scan_in_o | output | 1 | Serial bit to the scan chain |
| scan_en_o | output | 1 | High in every cycle that shifts a bit into the chain |
| capture_o | output | 1 | One-cycle pulse once the chain holds M bits |

## Verification
The assertions check on every cycle that a held block's output does not change, that each data phase lasts exactly `M` cycles and ends in a lone capture pulse, that the flag load happens only behind a set update flag, that the reset state is correct, and that a start pulse during shifting does not restart the sequence. Only the bench scenarios can show the actual bit content: that flags map to the right blocks, that reused flags persist across patterns, that sign bits are taken from the right stream position, and that the example polynomial emits the stated sequence. The bench shows these by comparing against a bit-serial model of the stream.

// File: rtl/hfd_pkg.sv
package hfd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_UPD  = 3'd1,
    ST_FLAG = 3'd2,
    ST_DATA = 3'd3,
    ST_CAPT = 3'd4
  } hfd_state_e;

  // width that holds values 0..n-1, never below one bit
  function automatic int idx_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // cycles per block
  function automatic int seg_len(input int m, input int b);
    return m / b;
  endfunction

  // larger of two counts
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hfd_lfsr.sv
module hfd_lfsr #(
  parameter int          L    = 16,
  parameter logic [L-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [L-1:0] seed,
  input  logic         adv,
  output logic         out_bit
);
  logic [L-1:0] q;
  logic         fb;

  assign fb      = ^(q & TAPS);
  assign out_bit = q[0];

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= seed;
    else if (adv)  q <= {fb, q[L-1:1]};
  end
endmodule

// File: rtl/hfd_ctrl.sv
module hfd_ctrl
  import hfd_pkg::*;
#(
  parameter int M = 32,
  parameter int B = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic upd_bit,
  output logic in_idle,
  output logic in_upd,
  output logic in_flag,
  output logic in_data,
  output logic in_capt,
  output logic seg_first,
  output logic seg_end
);
  localparam int SEG = seg_len(M, B);
  localparam int CW  = idx_width(max2(M, B));
  localparam int SW  = idx_width(SEG);

  hfd_state_e    st;
  logic [CW-1:0] cnt;
  logic [SW-1:0] seg;
  logic          seg_last;

  assign in_idle   = (st == ST_IDLE);
  assign in_upd    = (st == ST_UPD);
  assign in_flag   = (st == ST_FLAG);
  assign in_data   = (st == ST_DATA);
  assign in_capt   = (st == ST_CAPT);
  assign seg_last  = (seg == SW'(SEG - 1));
  assign seg_first = in_data && (seg == '0);
  assign seg_end   = in_data && seg_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
      seg <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) st <= ST_UPD;
        ST_UPD: begin
          cnt <= '0;
          seg <= '0;
          st  <= upd_bit ? ST_FLAG : ST_DATA;
        end
        ST_FLAG: begin
          if (cnt == CW'(B - 1)) begin
            cnt <= '0;
            st  <= ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          seg <= seg_last ? '0 : seg + 1'b1;
          if (cnt == CW'(M - 1)) begin
            cnt <= '0;
            st  <= ST_CAPT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hfd_holdreg.sv
module hfd_holdreg #(
  parameter int B = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_in,
  input  logic         upd_take,
  input  logic         flag_shift,
  input  logic         seg_first,
  input  logic         seg_end,
  output logic         upd_q,
  output logic [B-1:0] hold_q,
  output logic         scan_bit
);
  logic sign_q;

  assign scan_bit = (hold_q[0] || seg_first) ? bit_in : sign_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_q  <= 1'b0;
      sign_q <= 1'b0;
    end else begin
      if (upd_take)  upd_q  <= bit_in;
      if (seg_first) sign_q <= bit_in;
    end
  end

  generate
    if (B == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)             hold_q <= 1'b1;
        else if (flag_shift) hold_q <= bit_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)             hold_q <= '1;
        else if (flag_shift) hold_q <= {bit_in, hold_q[B-1:1]};
        else if (seg_end)    hold_q <= {hold_q[0], hold_q[B-1:1]};
      end
    end
  endgenerate
endmodule

// File: rtl/hfd_top.sv
module hfd_top #(
  parameter int           L    = 16,
  parameter logic [L-1:0] TAPS = 16'hB400,
  parameter int           M    = 32,
  parameter int           B    = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [L-1:0] seed_i,
  input  logic         seed_load_i,
  input  logic         start_i,
  output logic         scan_in_o,
  output logic         scan_en_o,
  output logic         capture_o
);
  logic         lfsr_bit;
  logic         in_idle, in_upd, in_flag, in_data, in_capt;
  logic         seg_first, seg_end;
  logic         upd_q;
  logic [B-1:0] hold_q;
  logic         hold_mid;
  logic         lfsr_adv;

  initial begin
    if (M % B != 0) $error("M must be a multiple of B");
  end

  assign lfsr_adv = in_upd || in_flag || in_data;
  // a held block after its first cycle: output must not move
  assign hold_mid = in_data && !hold_q[0] && !seg_first;

  hfd_lfsr #(.L(L), .TAPS(TAPS)) u_lfsr (
    .clk(clk), .rst(rst),
    .load(seed_load_i && in_idle), .seed(seed_i),
    .adv(lfsr_adv), .out_bit(lfsr_bit)
  );

  hfd_ctrl #(.M(M), .B(B)) u_ctrl (
    .clk(clk), .rst(rst), .start(start_i), .upd_bit(lfsr_bit),
    .in_idle(in_idle), .in_upd(in_upd), .in_flag(in_flag),
    .in_data(in_data), .in_capt(in_capt),
    .seg_first(seg_first), .seg_end(seg_end)
  );

  hfd_holdreg #(.B(B)) u_hold (
    .clk(clk), .rst(rst), .bit_in(lfsr_bit),
    .upd_take(in_upd), .flag_shift(in_flag),
    .seg_first(seg_first), .seg_end(seg_end),
    .upd_q(upd_q), .hold_q(hold_q), .scan_bit(scan_in_o)
  );

  assign scan_en_o = in_data;
  assign capture_o = in_capt;
endmodule

// File: rtl/hfd_chk.sv
module hfd_chk #(
  parameter int M = 32,
  parameter int B = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         scan_in_o,
  input logic         scan_en_o,
  input logic         capture_o,
  input logic         in_flag,
  input logic         in_upd,
  input logic         upd_q,
  input logic [B-1:0] hold_q,
  input logic         hold_mid
);
  localparam int DW = $clog2(M + 2);
  logic [DW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst)            dcnt <= '0;
    else if (capture_o) dcnt <= '0;
    else if (scan_en_o) dcnt <= dcnt + 1'b1;
  end

  // R8
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hold_q == '1) && !upd_q && !scan_en_o && !capture_o);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    hold_mid |-> $stable(scan_in_o));

  // R7
  data_len_chk: assert property (@(posedge clk) disable iff (rst)
    capture_o |-> dcnt == DW'(M));

  // R7
  capture_after_data_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(scan_en_o) |-> capture_o);

  // R7
  capture_single_chk: assert property (@(posedge clk) disable iff (rst)
    capture_o |=> !capture_o && !scan_en_o);

  // R3
  upd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    in_flag |-> upd_q);

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_en_o && start_i) |=> !in_upd);
endmodule

bind hfd_top hfd_chk #(.M(M), .B(B)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .scan_in_o(scan_in_o),
  .scan_en_o(scan_en_o), .capture_o(capture_o), .in_flag(in_flag),
  .in_upd(in_upd), .upd_q(upd_q), .hold_q(hold_q), .hold_mid(hold_mid)
);

// File: tb/tb_hfd_top.sv
module tb_hfd_top;
  localparam int           L    = 16;
  localparam logic [L-1:0] TAPS = 16'hB400;
  localparam int           M    = 32;
  localparam int           B    = 4;
  localparam int           SEG  = M / B;
  localparam int           NS   = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [L-1:0] seed = '0;
  logic seed_load = 1'b0, start = 1'b0;
  logic scan_in, scan_en, capture;
  logic [2:0] ex_seed = '0;
  logic ex_load = 1'b0, ex_start = 1'b0;
  logic ex_scan_in, ex_scan_en, ex_capture;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bit e [0:NS-1];
  int p;
  bit flags [0:B-1];
  bit expb [0:M-1];
  int exp_upd;

  always #10 clk = ~clk;

  hfd_top #(.L(L), .TAPS(TAPS), .M(M), .B(B)) dut (
    .clk(clk), .rst(rst), .seed_i(seed), .seed_load_i(seed_load),
    .start_i(start), .scan_in_o(scan_in), .scan_en_o(scan_en),
    .capture_o(capture)
  );

  hfd_top #(.L(3), .TAPS(3'b011), .M(7), .B(1)) dut_ex (
    .clk(clk), .rst(rst), .seed_i(ex_seed), .seed_load_i(ex_load),
    .start_i(ex_start), .scan_in_o(ex_scan_in), .scan_en_o(ex_scan_en),
    .capture_o(ex_capture)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // bit-serial restatement: bit n+L is the XOR of the tapped earlier bits
  task automatic gen_stream(input logic [L-1:0] s);
    for (int i = 0; i < L; i++) e[i] = s[i];
    for (int n = 0; n + L < NS; n++) begin
      bit x = 0;
      for (int k = 0; k < L; k++) if (TAPS[k]) x ^= e[n + k];
      e[n + L] = x;
    end
    p = 0;
  endtask

  task automatic model_pattern();
    exp_upd = e[p];
    p++;
    if (exp_upd != 0) begin
      for (int b = 0; b < B; b++) flags[b] = e[p + b];
      p += B;
    end
    for (int k = 0; k < M; k++) begin
      int blk = k / SEG;
      expb[k] = flags[blk] ? e[p + k] : e[p + blk * SEG];
    end
    p += M;
  endtask

  task automatic load_seed(input logic [L-1:0] s);
    @(negedge clk);
    seed = s; seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    gen_stream(s);
  endtask

  // disturb < 0: no stimulus during the pattern
  task automatic run_pattern(input int disturb, input string tag);
    int idx = 0, nd = 0, bad_bits = 0, cap_at = -1;
    int first_bad = -1;
    model_pattern();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cap_at < 0 && idx < M + B + 10) begin
      if (idx == disturb) begin
        seed = L'($urandom); seed_load = 1'b1; start = 1'b1;
      end else begin
        seed_load = 1'b0; start = 1'b0;
      end
      if (scan_en) begin
        if (nd < M && scan_in !== expb[nd]) begin
          bad_bits++;
          if (first_bad < 0) first_bad = nd;
        end
        nd++;
      end
      if (capture) cap_at = idx;
      if (cap_at < 0) begin
        idx++;
        @(negedge clk);
      end
    end
    seed_load = 1'b0; start = 1'b0;
    // R5/R6: scan bits follow flags and sign bits; R3/R4 decide the flags
    check(bad_bits == 0, "R5/R6", {tag, " scan bits, first bad index"},
          first_bad, -1);
    // R7: exactly M shift cycles
    check(nd == M, "R7", {tag, " shift cycles"}, nd, M);
    // R2/R3/R4: capture position counts update cycle and optional flag load
    check(cap_at == 1 + (exp_upd != 0 ? B : 0) + M, "R3/R4",
          {tag, " capture cycle"}, cap_at, 1 + (exp_upd != 0 ? B : 0) + M);
    @(negedge clk);
    check(!capture && !scan_en, "R7", {tag, " idle after capture"},
          int'(capture) + int'(scan_en), 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20241);
    for (int b = 0; b < B; b++) flags[b] = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state at the ports
    check(!scan_en && !capture, "R8", "outputs after reset",
          int'(scan_en) + int'(capture), 0);

    // R10: example polynomial and seed on the small instance
    begin
      bit exv [0:6] = '{0, 0, 1, 0, 1, 1, 1};
      int nd = 0, bad = 0;
      @(negedge clk);
      ex_seed = 3'b011; ex_load = 1'b1;
      @(negedge clk);
      ex_load = 1'b0; ex_start = 1'b1;
      @(negedge clk);
      ex_start = 1'b0;
      for (int i = 0; i < 20 && !ex_capture; i++) begin
        if (ex_scan_en) begin
          if (nd < 7 && ex_scan_in !== exv[nd]) bad++;
          nd++;
        end
        @(negedge clk);
      end
      check(bad == 0 && nd == 7, "R10", "example stream mismatches", bad, 0);
    end

    // R8/R4: seed with bit 0 = 0 right after reset keeps all-ones flags
    load_seed(16'hA5A4);
    run_pattern(-1, "R8 reset flags pass-through");
    // R1/R4: continue without reseed, stream carries on
    run_pattern(-1, "R1 continued stream");
    // R3: seed with bit 0 = 1 forces a flag load
    load_seed(16'h0F0B);
    run_pattern(-1, "R3 forced flag load");
    // R9: seed load and start pulsed mid-shift are ignored
    run_pattern(B + 5, "R9 busy stimulus");
    run_pattern(3, "R9 busy stimulus early");

    // R1/R5/R6: random seeds, several patterns each
    for (int s = 0; s < 12; s++) begin
      load_seed(L'($urandom));
      for (int k = 0; k < 3; k++)
        run_pattern((k == 1) ? int'($urandom_range(2, M)) : -1, "R1 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule